// File: doc/BRIEF.md
# Gap-Length Coded Frame Transmitter

This block sends a short command frame toward a passive tag by switching a carrier-enable output off and on. Every symbol opens with a carrier-off gap of fixed length, after which the carrier comes back on. The total length of the symbol, gap included, carries the bit value: a long symbol is a one, a short symbol is a zero. Bits are taken from the data word starting with the least significant bit. After the last bit, one more gap closes the frame and the carrier is switched back on.

All timing is counted in ticks of a prescaled timebase, by default one tick every 32 system clocks. When the closing gap ends, the block clears a response-timing counter. The counter then counts ticks, so a companion receiver can time the tag's reply from the end of the frame. A caller loads a data word and a bit count and pulses start. The busy flag stays high for the whole frame, and done pulses once when the frame is over.

Top module: `gltx_top`

## Requirements
- R1: After reset the carrier output is high, busy and done are low and the response counter reads 0.
- R2: From the clock after an accepted start, each symbol begins with the carrier low for exactly PAUSE_TICKS*TICK_DIV clocks. Busy is high from that clock until the frame ends.
- R3: A bit of value 1 lasts ONE_TICKS*TICK_DIV clocks in total: its gap plus the carrier-high time that follows it.
- R4: A bit of value 0 lasts ZERO_TICKS*TICK_DIV clocks in total, gap included.
- R5: Bits are sent in order from data bit 0 upward, one bit per symbol.
- R6: After the last symbol, the carrier is low for exactly PAUSE_TICKS*TICK_DIV clocks. The carrier then returns high and stays high while the block is idle.
- R7: Done is high for exactly one clock, in the first clock the carrier is high again after the closing gap. Busy is low in that same clock.
- R8: The response counter reads 0 in the done clock. After that it increases by one every TICK_DIV clocks, so it reads k exactly k*TICK_DIV clocks after the done clock.
- R9: A bit count greater than MAX_BITS is treated as MAX_BITS.
- R10: A bit count of 0 sends no symbols, only the closing gap, followed by the done pulse.
- R11: A start pulse while busy is high is ignored, together with the data and count presented with it. The frame in progress continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Frame request strobe, accepted only when idle |
| tx_data | input | MAX_BITS | Frame bits, bit 0 sent first |
| tx_count | input | CNT_W | Number of bits to send, clamped to MAX_BITS |
| carrier_en | output | 1 | Carrier enable, low during gaps |
| busy | output | 1 | High while a frame is being sent |
| done | output | 1 | One-clock pulse at frame end |
| resp_ticks | output | RESP_W | Ticks elapsed since the last frame end |

## Verification
The bench sweeps every bit count from 0 to MAX_BITS and a few counts beyond it. It rebuilds each frame from the carrier waveform by measuring every low run and high run in clocks. It then compares each symbol's length and bit value, and the total number of symbols, against values computed from the timing parameters.

A design that sends the most significant bit first, or gets a symbol or gap length off by one tick, shows up as a wrong bit or a wrong run length. A design that mishandles the clamp or the zero count shows up as a wrong number of symbols. A start taken while busy would restart the frame or change its bits.

The bench also checks that done is a single clock with busy already low. It checks that the response counter starts from zero exactly at done and counts one step per tick after it. A design that clears the counter one tick late, or never clears it, gives the wrong reading.

// File: rtl/gltx_pkg.sv
package gltx_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_GAP  = 2'd1,
      ST_MARK = 2'd2,
      ST_TAIL = 2'd3
   } gltx_state_t;

endpackage

// File: rtl/gltx_tick.sv
module gltx_tick #(
   parameter int TICK_DIV = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   output logic tick
);

   localparam int PW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;

   generate
      if (TICK_DIV < 2) begin : g_bad_div
         $error("gltx_tick: TICK_DIV must be at least 2");
      end
   endgenerate

   logic [PW-1:0] pre_q;

   assign tick = (pre_q == PW'(TICK_DIV - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pre_q <= '0;
      else if (clr)     pre_q <= '0;
      else if (tick)    pre_q <= '0;
      else              pre_q <= pre_q + 1'b1;
   end

   AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick); // R2

endmodule

// File: rtl/gltx_resp.sv
module gltx_resp #(
   parameter int RESP_W   = 16,
   parameter bit SATURATE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              tick,
   output logic [RESP_W-1:0] count
);

   generate
      if (RESP_W < 2) begin : g_bad_w
         $error("gltx_resp: RESP_W must be at least 2");
      end
   endgenerate

   logic [RESP_W-1:0] cnt_q;
   logic              step;

   generate
      if (SATURATE) begin : g_sat
         assign step = tick && (cnt_q != {RESP_W{1'b1}});
      end else begin : g_wrap
         assign step = tick;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt_q <= '0;
      else if (clr)   cnt_q <= '0;
      else if (step)  cnt_q <= cnt_q + 1'b1;
   end

   assign count = cnt_q;

   AST_RESP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !tick) |=> $stable(cnt_q)); // R8

endmodule

// File: rtl/gltx_seq.sv
module gltx_seq
   import gltx_pkg::*;
#(
   parameter int MAX_BITS   = 16,
   parameter int CNT_W      = 5,
   parameter int PAUSE_TICKS = 30,
   parameter int ONE_TICKS  = 150,
   parameter int ZERO_TICKS = 90
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tick,
   input  logic                start,
   input  logic [MAX_BITS-1:0] data,
   input  logic [CNT_W-1:0]    count,
   output logic                carrier_en,
   output logic                busy,
   output logic                done,
   output logic                frame_start,
   output logic                frame_end
);

   localparam int BW = $clog2(MAX_BITS + 1);
   localparam int TW = $clog2(ONE_TICKS + 1);

   generate
      if (CNT_W < BW) begin : g_bad_cnt
         $error("gltx_seq: CNT_W too narrow for MAX_BITS");
      end
      if (PAUSE_TICKS < 1 || ZERO_TICKS <= PAUSE_TICKS || ONE_TICKS <= ZERO_TICKS) begin : g_bad_time
         $error("gltx_seq: need 1 <= PAUSE_TICKS < ZERO_TICKS < ONE_TICKS");
      end
   endgenerate

   gltx_state_t         state_q;
   logic [TW-1:0]       tcnt_q;
   logic [MAX_BITS-1:0] shreg_q;
   logic [BW-1:0]       left_q;
   logic                done_q;

   logic                accept;
   logic [BW-1:0]       nbits;
   logic                gap_last;
   logic                sym_last;

   assign accept   = start && (state_q == ST_IDLE);
   assign nbits    = (count > CNT_W'(MAX_BITS)) ? BW'(MAX_BITS) : count[BW-1:0];
   assign gap_last = tick && (tcnt_q == TW'(PAUSE_TICKS - 1));
   assign sym_last = tick && (tcnt_q == (shreg_q[0] ? TW'(ONE_TICKS - 1) : TW'(ZERO_TICKS - 1)));

   assign frame_start = accept;
   assign frame_end   = (state_q == ST_TAIL) && gap_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         tcnt_q  <= '0;
         shreg_q <= '0;
         left_q  <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= frame_end;
         unique case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  shreg_q <= data;
                  left_q  <= nbits;
                  tcnt_q  <= '0;
                  state_q <= (nbits == '0) ? ST_TAIL : ST_GAP;
               end
            end
            ST_GAP: begin
               if (tick) begin
                  tcnt_q <= tcnt_q + 1'b1;
                  if (gap_last) state_q <= ST_MARK;
               end
            end
            ST_MARK: begin
               if (sym_last) begin
                  tcnt_q  <= '0;
                  shreg_q <= shreg_q >> 1;
                  left_q  <= left_q - 1'b1;
                  state_q <= (left_q == BW'(1)) ? ST_TAIL : ST_GAP;
               end else if (tick) begin
                  tcnt_q <= tcnt_q + 1'b1;
               end
            end
            ST_TAIL: begin
               if (gap_last) begin
                  tcnt_q  <= '0;
                  state_q <= ST_IDLE;
               end else if (tick) begin
                  tcnt_q <= tcnt_q + 1'b1;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign carrier_en = !((state_q == ST_GAP) || (state_q == ST_TAIL));
   assign busy       = (state_q != ST_IDLE);
   assign done       = done_q;

   AST_LEFT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      left_q <= BW'(MAX_BITS)); // R9

   AST_ZERO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && nbits == '0) |=> (state_q == ST_TAIL)); // R10

   AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && !tick) |=> ($stable(shreg_q) && $stable(left_q))); // R11

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R7

   AST_IDLE_CARRIER: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (carrier_en && !busy)); // R6

endmodule

// File: rtl/gltx_top.sv
module gltx_top #(
   parameter int MAX_BITS    = 16,
   parameter int CNT_W       = 5,
   parameter int TICK_DIV    = 32,
   parameter int PAUSE_TICKS = 30,
   parameter int ONE_TICKS   = 150,
   parameter int ZERO_TICKS  = 90,
   parameter int RESP_W      = 16,
   parameter bit RESP_SAT    = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [MAX_BITS-1:0] tx_data,
   input  logic [CNT_W-1:0]    tx_count,
   output logic                carrier_en,
   output logic                busy,
   output logic                done,
   output logic [RESP_W-1:0]   resp_ticks
);

   logic tick;
   logic frame_start;
   logic frame_end;

   gltx_tick #(.TICK_DIV(TICK_DIV)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (frame_start | frame_end),
      .tick  (tick)
   );

   gltx_seq #(
      .MAX_BITS    (MAX_BITS),
      .CNT_W       (CNT_W),
      .PAUSE_TICKS (PAUSE_TICKS),
      .ONE_TICKS   (ONE_TICKS),
      .ZERO_TICKS  (ZERO_TICKS)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick        (tick),
      .start       (start),
      .data        (tx_data),
      .count       (tx_count),
      .carrier_en  (carrier_en),
      .busy        (busy),
      .done        (done),
      .frame_start (frame_start),
      .frame_end   (frame_end)
   );

   gltx_resp #(.RESP_W(RESP_W), .SATURATE(RESP_SAT)) u_resp (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (frame_end),
      .tick  (tick),
      .count (resp_ticks)
   );

   AST_RESP_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (resp_ticks == '0)); // R8

endmodule

// File: tb/gltx_top_bench.sv
`timescale 1ns/1ps
module gltx_top_bench;

   localparam int MB = 16;
   localparam int CW = 5;
   localparam int D  = 2;
   localparam int P  = 3;
   localparam int L1 = 9;
   localparam int L0 = 6;
   localparam int RW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [MB-1:0] tx_data = '0;
   logic [CW-1:0] tx_count = '0;
   logic          carrier_en, busy, done;
   logic [RW-1:0] resp_ticks;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   gltx_top #(
      .MAX_BITS(MB), .CNT_W(CW), .TICK_DIV(D), .PAUSE_TICKS(P),
      .ONE_TICKS(L1), .ZERO_TICKS(L0), .RESP_W(RW), .RESP_SAT(1'b1)
   ) u_gltx_top (
      .clk(clk), .rst_n(rst_n), .start(start), .tx_data(tx_data),
      .tx_count(tx_count), .carrier_en(carrier_en), .busy(busy),
      .done(done), .resp_ticks(resp_ticks)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic run_frame(input logic [MB-1:0] d, input int c, input bit ign);
      int n, bits, lo, hi, expl;
      bit fin, bv;
      n = (c > MB) ? MB : c;
      @(negedge clk);
      start = 1'b1; tx_data = d; tx_count = CW'(c);
      @(negedge clk);
      start = 1'b0; tx_data = ~d; tx_count = 5'd3;
      chk(busy == 1'b1, "R2 busy after start", int'(busy), 1);
      bits = 0; fin = 1'b0;
      while (!fin) begin
         lo = 0;
         while (!carrier_en) begin
            lo++;
            if (ign && bits == 0 && lo == 1) begin
               start = 1'b1; tx_data = ~d; tx_count = 5'd2;
            end
            if (ign && bits == 0 && lo == 2) start = 1'b0;
            @(negedge clk);
         end
         if (done) begin
            chk(lo == P*D, "R6 closing gap length", lo, P*D);
            chk(busy == 1'b0, "R7 busy low at done", int'(busy), 0);
            chk(resp_ticks == 0, "R8 response counter at done", int'(resp_ticks), 0);
            fin = 1'b1;
         end else begin
            chk(lo == P*D, "R2 symbol gap length", lo, P*D);
            hi = 0;
            while (carrier_en) begin
               hi++;
               @(negedge clk);
            end
            bv = (bits < MB) ? d[bits] : 1'b0;
            expl = bv ? L1*D : L0*D;
            chk(lo + hi == expl, bv ? "R3 one-bit length" : "R4 zero-bit length", lo + hi, expl);
            chk(bits < n, "R5 bit order / symbol overrun", bits, n);
            bits++;
         end
      end
      if (c == 0) chk(bits == 0, "R10 zero count symbols", bits, 0);
      else if (c > MB) chk(bits == MB, "R9 clamped symbols", bits, MB);
      else chk(bits == n, "R5 symbol count", bits, n);
      if (ign) chk(bits == n, "R11 start while busy ignored", bits, n);
      @(negedge clk);
      chk(done == 1'b0, "R7 done single clock", int'(done), 0);
      chk(carrier_en == 1'b1, "R6 carrier idles high", int'(carrier_en), 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(carrier_en == 1'b1, "R1 reset carrier", int'(carrier_en), 1);
      chk(busy == 1'b0, "R1 reset busy", int'(busy), 0);
      chk(done == 1'b0, "R1 reset done", int'(done), 0);
      chk(resp_ticks == 0, "R1 reset response counter", int'(resp_ticks), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      for (int c = 0; c <= MB + 1; c++)
         run_frame(16'hB61D ^ MB'(c * 16'h1357), c, 1'b0);
      run_frame(16'hFFFF, 16, 1'b0);
      run_frame(16'h0000, 16, 1'b0);
      run_frame(16'h0001, 31, 1'b0);
      run_frame(16'h8000, 16, 1'b0);
      run_frame(16'h00F3, 8, 1'b1);

      // R8: counter steps once per tick after the frame end
      run_frame(16'h002D, 6, 1'b0);
      repeat (3*D - 1) @(negedge clk);
      chk(resp_ticks == 3, "R8 response counter after 3 ticks", int'(resp_ticks), 3);
      repeat (2*D) @(negedge clk);
      chk(resp_ticks == 5, "R8 response counter after 5 ticks", int'(resp_ticks), 5);

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(4 * 150000);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual 0 expected 1");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule